// File: doc/BRIEF.md
# PCM Voice Serial Port

This block joins a codec's parallel sample datapath to a framed serial voice link. It runs on one master clock. A frame-sync pulse marks the start of each frame, and one 14-bit two's complement sample crosses the link in each direction per frame. Both directions send the most significant bit first. The frame-sync and serial-in lines are captured on the falling clock edge. All state changes and the serial output happen after the rising edge.

On the transmit side, a one-word holding register accepts samples through a valid/ready handshake. The held word is taken at frame start and shifted out. If the holding register is empty at frame start, an all-zero word is sent instead. On the receive side, the 14 bits are assembled, the finished word is presented on a parallel output, and a one-cycle strobe flags it. A loopback control replaces the transmit word with the last complete received word.

The control is a three-state machine. IDLE waits for the first frame. SHIFT moves the 14 bits. PAD keeps the line at zero until the next frame sync. The transitions are:
- IDLE to SHIFT on a frame start.
- SHIFT to PAD after the 14th bit.
- PAD to SHIFT on a frame start.
- SHIFT to SHIFT on a frame start that arrives mid-word (restart).

Top module: `pcm_voice_port`

## Requirements
- R1: After reset, `sout` is 0, `rx_valid` is 0, `rx_data` is 0 and `tx_ready` is 1, and they stay so while no frame sync arrives.
- R2: A frame starts at the first rising clock edge after a falling edge that samples `fs` high when it was low at the previous falling edge. During the following 14 clock periods, `sout` carries the transmit word, bit 13 first and bit 0 last, one bit per period.
- R3: Outside those 14 periods, `sout` is 0. This covers the padding up to the next frame sync and the time before the first frame.
- R4: `sin` is sampled on the falling edge in each of the same 14 periods, bit 13 first. The result is the received word.
- R5: `rx_valid` is high for exactly one cycle, starting at the rising edge that ends the 14th bit period. `rx_data` shows the new word from that edge and holds it until the next completed word.
- R6: `tx_ready` is 1 exactly when the holding register is empty. A rising edge with `tx_valid` and `tx_ready` both high stores `tx_data`. At a frame start with loopback off, the held word is sent and the register empties. If the register is empty at that frame start, the word sent is 0.
- R7: When `loop_en` is 1 at a frame start, the word sent is the last completed received word (0 after reset). The holding register is left untouched.
- R8: Keeping `fs` high for several clocks starts only one frame.
- R9: A frame sync that arrives before the 14th bit restarts the frame with a new word from its MSB. The partial receive word is dropped: there is no `rx_valid` and `rx_data` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fs | input | 1 | Frame sync, sampled on the falling edge |
| sin | input | 1 | Serial receive data, sampled on the falling edge |
| loop_en | input | 1 | Serial loopback select, read at frame start |
| tx_data | input | 14 | Transmit sample offered to the holding register |
| tx_valid | input | 1 | Transmit sample valid |
| tx_ready | output | 1 | Holding register empty |
| sout | output | 1 | Serial transmit data |
| rx_data | output | 14 | Last completed received sample |
| rx_valid | output | 1 | One-cycle strobe for a new received sample |

## Verification
The bench compares every clock period of `sout`, `rx_valid` and `tx_ready` against a model of frame position and holding-register state. This catches an off-by-one frame start, which would shift every bit by one period. It also catches a bit order reversed between MSB-first and LSB-first.

Frames are cut short mid-word. A design that failed to drop the partial word would raise `rx_valid` or corrupt `rx_data`. Wide frame-sync pulses are driven, and a level-triggered design would restart on them. Loopback frames check that the echoed word is the previous receive word and that the pending transmit sample survives. A design that consumed it would leave `tx_ready` high and send the wrong word in the next normal frame.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_PAD   = 2'd2
    } port_state_t;
endpackage

// File: rtl/pcm_fall_sampler.sv
module pcm_fall_sampler #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    // Serial-side inputs are captured half a cycle before the logic uses them.
    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end
endmodule

// File: rtl/pcm_tx_hold.sv
module pcm_tx_hold #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    output logic         tx_ready,
    input  logic         take,
    output logic [W-1:0] hold,
    output logic         full
);
    assign tx_ready = !full;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold <= '0;
            full <= 1'b0;
        end else if (take) begin
            full <= 1'b0;
        end else if (tx_valid && !full) begin
            hold <= tx_data;
            full <= 1'b1;
        end
    end

    // R6
    hold_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> (!tx_ready && hold == $past(tx_data)));

    // R6
    take_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> tx_ready);
endmodule

// File: rtl/pcm_port_fsm.sv
module pcm_port_fsm
    import pcm_port_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fs_s,
    input  logic         sin_s,
    input  logic         loop_en,
    input  logic [W-1:0] hold,
    input  logic         hold_full,
    output logic         take,
    output logic         sout,
    output logic [W-1:0] rx_data,
    output logic         rx_valid
);
    localparam int CNT_W = $clog2(W);

    port_state_t      state, nxt;
    logic             fs_prev;
    logic [CNT_W-1:0] cnt;
    logic [W-1:0]     tx_sh;
    logic [W-2:0]     rx_sh;
    logic             start;
    logic             last_bit;
    logic [W-1:0]     load_word;

    assign start     = fs_s && !fs_prev;
    assign last_bit  = (state == ST_SHIFT) && (cnt == CNT_W'(W - 1));
    assign take      = start && !loop_en && hold_full;
    assign load_word = loop_en ? rx_data : (hold_full ? hold : '0);
    assign sout      = (state == ST_SHIFT) && tx_sh[W-1];

    // Next-state decision
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  nxt = start ? ST_SHIFT : ST_IDLE;
            ST_SHIFT: begin
                if (start)         nxt = ST_SHIFT;
                else if (last_bit) nxt = ST_PAD;
                else               nxt = ST_SHIFT;
            end
            ST_PAD:   nxt = start ? ST_SHIFT : ST_PAD;
            default:  nxt = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Datapath and outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_prev  <= 1'b0;
            cnt      <= '0;
            tx_sh    <= '0;
            rx_sh    <= '0;
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            fs_prev  <= fs_s;
            rx_valid <= 1'b0;
            if (start) begin
                cnt   <= '0;
                tx_sh <= load_word;
                rx_sh <= '0;
            end else if (state == ST_SHIFT) begin
                cnt   <= cnt + 1'b1;
                tx_sh <= {tx_sh[W-2:0], 1'b0};
                rx_sh <= {rx_sh[W-3:0], sin_s};
                if (last_bit) begin
                    rx_data  <= {rx_sh, sin_s};
                    rx_valid <= 1'b1;
                end
            end
        end
    end

    // R2
    start_enters_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (state == ST_SHIFT && cnt == '0));

    // R2
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SHIFT) |-> (cnt <= CNT_W'(W - 1)));

    // R5
    rx_valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R3
    idle_after_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> !sout);

    // R9
    restart_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!rx_valid && $stable(rx_data)));
endmodule

// File: rtl/pcm_voice_port.sv
module pcm_voice_port #(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         fs,
    input  logic         sin,
    input  logic         loop_en,
    input  logic [W-1:0] tx_data,
    input  logic         tx_valid,
    output logic         tx_ready,
    output logic         sout,
    output logic [W-1:0] rx_data,
    output logic         rx_valid
);
    logic [1:0]   smp;
    logic         take;
    logic         hold_full;
    logic [W-1:0] hold;

    pcm_fall_sampler #(.N(2)) u_smp (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({fs, sin}),
        .q     (smp)
    );

    pcm_tx_hold #(.W(W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .tx_data  (tx_data),
        .tx_valid (tx_valid),
        .tx_ready (tx_ready),
        .take     (take),
        .hold     (hold),
        .full     (hold_full)
    );

    pcm_port_fsm #(.W(W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .fs_s      (smp[1]),
        .sin_s     (smp[0]),
        .loop_en   (loop_en),
        .hold      (hold),
        .hold_full (hold_full),
        .take      (take),
        .sout      (sout),
        .rx_data   (rx_data),
        .rx_valid  (rx_valid)
    );
endmodule

// File: tb/tb_pcm_voice_port.sv
module tb_pcm_voice_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fs = 1'b0;
    logic        sin = 1'b0;
    logic        loop_en = 1'b0;
    logic [13:0] tx_data = '0;
    logic        tx_valid = 1'b0;
    logic        tx_ready;
    logic        sout;
    logic [13:0] rx_data;
    logic        rx_valid;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // bench model state
    bit          m_full = 1'b0;
    logic [13:0] m_hold = '0;
    logic [13:0] m_last = '0;
    bit          carry = 1'b0;

    always #4 clk = ~clk;

    pcm_voice_port dut (
        .clk(clk), .rst_n(rst_n), .fs(fs), .sin(sin), .loop_en(loop_en),
        .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .sout(sout), .rx_data(rx_data), .rx_valid(rx_valid)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [13:0] pick_word(input bit lp);
        return lp ? m_last : (m_full ? m_hold : 14'd0);
    endfunction

    task automatic run_frame(input logic [13:0] rxw, input int len, input int fs_w,
                             input bit lp, input bit push, input logic [13:0] pw);
        logic [13:0] exp_tx;
        bit          acc;
        bit          e_sout;
        exp_tx = pick_word(lp);
        acc = 1'b0;
        for (int c = 0; c < len; c++) begin
            @(posedge clk);
            #1;
            fs       = (c < fs_w);
            loop_en  = lp;
            sin      = (c >= 1 && c <= 14) ? rxw[14-c] : 1'($urandom_range(0, 1));
            tx_valid = push && (c == 20);
            tx_data  = (c == 20) ? pw : 14'($urandom);
            if (c == 1 && !lp) m_full = 1'b0;           // R6 consumed at frame start
            if (c == 20) acc = push && !m_full;
            if (c == 21 && acc) begin m_full = 1'b1; m_hold = pw; end
            #1;
            if (c == 0)       e_sout = carry;
            else if (c <= 14) e_sout = exp_tx[14-c];
            else              e_sout = 1'b0;
            chk(sout == e_sout, (c >= 1 && c <= 14) ? "R2 sout bit" : "R3 sout pad", int'(sout), int'(e_sout));
            chk(rx_valid == (c == 15), "R5 rx_valid", int'(rx_valid), int'(c == 15));
            chk(tx_ready == !m_full, "R6 tx_ready", int'(tx_ready), int'(!m_full));
            if (c == 0) chk(rx_data == m_last, "R9 rx_data kept", int'(rx_data), int'(m_last));
            if (c == 15) begin
                chk(rx_data == rxw, "R4 rx_data", int'(rx_data), int'(rxw));
                m_last = rxw;
            end
        end
        carry = (len <= 14) ? exp_tx[14-len] : 1'b0;
    endtask

    initial begin
        void'($urandom(32'd20240517));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        // R1 reset state and idle line
        for (int i = 0; i < 5; i++) begin
            @(posedge clk);
            #2;
            chk(sout == 1'b0, "R1 sout", int'(sout), 0);
            chk(rx_valid == 1'b0, "R1 rx_valid", int'(rx_valid), 0);
            chk(rx_data == 14'd0, "R1 rx_data", int'(rx_data), 0);
            chk(tx_ready == 1'b1, "R1 tx_ready", int'(tx_ready), 1);
        end
        // directed: empty hold sends zero, then pattern, extremes (R2 R4 R6)
        run_frame(14'h1234, 256, 1, 1'b0, 1'b1, 14'h2AAA);
        run_frame(14'h3FFF, 256, 1, 1'b0, 1'b1, 14'h1FFF);
        // R8 wide frame sync
        run_frame(14'h2000, 40, 3, 1'b0, 1'b1, 14'h2000);
        // R9 frame cut short mid-word
        run_frame(14'h0001, 7, 1, 1'b0, 1'b0, 14'h0);
        run_frame(14'h1555, 30, 1, 1'b0, 1'b0, 14'h0);
        // R7 loopback keeps the pending word
        run_frame(14'h0ABC, 30, 1, 1'b1, 1'b1, 14'h0F0F);
        run_frame(14'h0333, 30, 1, 1'b1, 1'b0, 14'h0);
        run_frame(14'h2DEF, 30, 1, 1'b0, 1'b0, 14'h0);
        // constrained random frames
        for (int n = 0; n < 40; n++) begin
            int kind;
            kind = int'($urandom_range(0, 9));
            if (kind == 0)
                run_frame(14'($urandom), int'($urandom_range(3, 13)), 1, 1'($urandom_range(0, 3) == 0), 1'b0, 14'h0);
            else if (kind == 1)
                run_frame(14'($urandom), int'($urandom_range(16, 20)), int'($urandom_range(1, 3)),
                          1'($urandom_range(0, 3) == 0), 1'b0, 14'h0);
            else
                run_frame(14'($urandom), int'($urandom_range(21, 260)), int'($urandom_range(1, 3)),
                          1'($urandom_range(0, 3) == 0), 1'($urandom_range(0, 9) < 7), 14'($urandom));
        end
        run_frame(14'h0F0F, 20, 1, 1'b0, 1'b0, 14'h0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule